// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetch Engine

This block feeds a display pipeline with raw frame words. Software writes the address of a first frame descriptor and sets the run bit. The engine then reads that four-word descriptor from memory (link to the following descriptor, frame start address, frame tag, command word). The low 24 bits of the command give the frame size in 32-bit words. The two top bits ask for a frame-start and a frame-end event. The engine fetches the frame as a series of bursts into an internal word FIFO, then follows the link. A descriptor that links to itself makes one buffer repeat on every frame.

Bursts are 4, 8 or 16 words, as a control field selects. The last burst of a frame is cut to the words that remain. A burst is only issued when the FIFO has space for all of it, so a slow consumer stalls the fetch and no word is lost. Three sticky event flags (frame start, frame end, output underrun) drive a single interrupt line. Each flag is gated by its own enable bit.

The controller's states are IDLE, DESC_REQ, DESC_WAIT, DATA_REQ and DATA_WAIT. Its transitions are:
- IDLE to DESC_REQ when the run bit is set.
- DESC_REQ to DESC_WAIT when the memory accepts the request.
- DESC_WAIT to DATA_REQ when the fourth descriptor word arrives.
- DATA_REQ to DATA_WAIT when a burst is accepted.
- DATA_WAIT back to DATA_REQ when the last word of the burst arrives.
- DATA_REQ to DESC_REQ when the frame is exhausted and run is still set.
- DATA_REQ to IDLE when the frame is exhausted and run is clear.

Top module: `fdma_fetch`

## Requirements
- R1: After reset the FIFO is empty, mem_req and irq are low, and the control, status and descriptor-pointer registers all read zero.
- R2: When the run bit (control bit 3) is set in IDLE, the engine requests 4 words at the descriptor-pointer address (offset 0x40). It takes the returned words in this order: link, frame start, frame tag, command.
- R3: mem_req stays high with mem_addr and mem_len unchanged until mem_ack is seen. Read words come back on mem_rvalid in ascending address order.
- R4: Burst size comes from control bits [29:28]: 0 gives 4 words, 1 gives 8 words, 2 and 3 give 16 words. Each data request has mem_len equal to the smaller of that size and the words left in the frame. Its address is the frame start plus 4 times the words already requested.
- R5: A data burst is requested only when the free FIFO space is at least its length. The FIFO never overflows, and no data is lost across a consumer stall.
- R6: The next descriptor is requested only after every word of the current frame has been received, and it is read from the link word. Offset 0x40 then reads the link value. A self-link repeats the same frame.
- R7: Offsets 0x44, 0x48 and 0x4C read the frame start, frame tag and command of the most recently loaded descriptor.
- R8: Status bit 1 (frame start) sets when a descriptor with command bit 31 loads while control bit 12 is set. Status bit 2 (frame end) sets after the last word of a frame whose command bit 30 is set, while control bit 13 is set.
- R9: Status bit 0 (underrun) sets when pix_rd is high while pix_empty is high and control bit 11 is set. With bit 11 clear, the same event has no effect.
- R10: A write to the status register (offset 0x34) ANDs the flags with the written data, so writing zero clears them all. irq is high exactly when some flag is set.
- R11: Clearing the run bit lets the current frame finish. The engine then returns to IDLE and fetches no further descriptor.
- R12: pix_data shows the oldest FIFO word whenever pix_empty is low. pix_rd removes it. Words leave in fetch order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 32 | Read byte address |
| mem_len | output | 5 | Read length in words |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |
| pix_rd | input | 1 | Consumer pop |
| pix_data | output | 32 | FIFO head word |
| pix_empty | output | 1 | FIFO empty |
| irq | output | 1 | OR of status flags |

## Verification
The assertions assume the following about the inputs:
- The memory returns exactly mem_len words after each accepted request.
- mem_rvalid is never raised without a pending request.
- Software leaves the burst field unchanged while a request is waiting for its accept.

The bench memory model keeps to these rules, inserting gaps between return words but never extra words. The bench writes the control register only at frame-independent points: once at the start of a case and once to clear run. It sweeps all three burst sizes against frame lengths that give exact, short and multi-burst fills.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h30;
    localparam logic [7:0] OFS_STAT = 8'h34;
    localparam logic [7:0] OFS_DPTR = 8'h40;
    localparam logic [7:0] OFS_SRC  = 8'h44;
    localparam logic [7:0] OFS_TAG  = 8'h48;
    localparam logic [7:0] OFS_CMD  = 8'h4C;

    localparam int DESC_WORDS = 4;
    localparam int MAX_BURST  = 16;
    localparam int BLEN_W     = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_DATA_REQ,
        ST_DATA_WAIT
    } fdf_state_e;

    typedef struct packed {
        logic [1:0] burst;
        logic       end_en;
        logic       start_en;
        logic       ufl_en;
        logic       run;
    } fdf_ctrl_t;

    function automatic logic [BLEN_W-1:0] burst_words(input logic [1:0] code);
        unique case (code)
            2'd0:    burst_words = BLEN_W'(4);
            2'd1:    burst_words = BLEN_W'(8);
            default: burst_words = BLEN_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/fdf_fifo.sv
module fdf_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_pop;

    assign empty  = (count == '0);
    assign do_pop = pop && !empty;
    assign dout   = store[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) bump = '0;
        else                        bump = p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (do_pop) rd_ptr <= bump(rd_ptr);
            unique case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

endmodule

// File: rtl/fdf_regs.sv
module fdf_regs
    import fdf_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dptr_load,
    input  logic [31:0] dptr_next,
    input  logic [31:0] cur_src,
    input  logic [31:0] cur_tag,
    input  logic [31:0] cur_cmd,
    input  logic        ev_start,
    input  logic        ev_end,
    input  logic        ev_ufl,
    output fdf_ctrl_t   ctrl,
    output logic [31:0] dptr,
    output logic        irq
);

    logic [2:0] flags;
    logic [2:0] flags_nx;

    always_comb begin
        flags_nx = flags;
        if (reg_wr && reg_addr == OFS_STAT) flags_nx = flags_nx & reg_wdata[2:0];
        if (ev_ufl   && ctrl.ufl_en)   flags_nx[0] = 1'b1;
        if (ev_start && ctrl.start_en) flags_nx[1] = 1'b1;
        if (ev_end   && ctrl.end_en)   flags_nx[2] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            dptr  <= '0;
            flags <= '0;
        end else begin
            flags <= flags_nx;
            if (reg_wr && reg_addr == OFS_CTRL) begin
                ctrl.burst    <= reg_wdata[29:28];
                ctrl.end_en   <= reg_wdata[13];
                ctrl.start_en <= reg_wdata[12];
                ctrl.ufl_en   <= reg_wdata[11];
                ctrl.run      <= reg_wdata[3];
            end
            if (dptr_load)                              dptr <= dptr_next;
            else if (reg_wr && reg_addr == OFS_DPTR)    dptr <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = {2'b00, ctrl.burst, 14'd0, ctrl.end_en, ctrl.start_en,
                                   ctrl.ufl_en, 7'd0, ctrl.run, 3'd0};
            OFS_STAT: reg_rdata = {29'd0, flags};
            OFS_DPTR: reg_rdata = dptr;
            OFS_SRC:  reg_rdata = cur_src;
            OFS_TAG:  reg_rdata = cur_tag;
            OFS_CMD:  reg_rdata = cur_cmd;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |flags;

endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
    import fdf_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int FIFO_DEPTH = 32,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fdf_ctrl_t         ctrl,
    input  logic [31:0]       dptr,
    input  logic [CNT_W-1:0]  fifo_cnt,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    output logic [BLEN_W-1:0] mem_len,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              push,
    output logic [31:0]       push_data,
    output logic              dptr_load,
    output logic [31:0]       dptr_next,
    output logic [31:0]       cur_src,
    output logic [31:0]       cur_tag,
    output logic [31:0]       cur_cmd,
    output logic              ev_start,
    output logic              ev_end,
    output fdf_state_e        state
);

    fdf_state_e        state_nx;
    logic [1:0]        wcnt;
    logic [BLEN_W-1:0] bcnt;
    logic [31:0]       src_ptr;
    logic [LEN_W-1:0]  remain;
    logic [31:0]       link;
    logic [BLEN_W-1:0] bsize;
    logic [BLEN_W-1:0] blen;
    logic              room;
    logic              frame_done;
    logic              desc_last;

    assign bsize      = burst_words(ctrl.burst);
    assign blen       = (remain < LEN_W'(bsize)) ? BLEN_W'(remain) : bsize;
    assign room       = (FIFO_DEPTH - int'(fifo_cnt)) >= int'(blen);
    assign frame_done = (remain == '0);
    assign desc_last  = (state == ST_DESC_WAIT) && mem_rvalid && (wcnt == 2'd3);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (ctrl.run) state_nx = ST_DESC_REQ;
            ST_DESC_REQ:  if (mem_ack) state_nx = ST_DESC_WAIT;
            ST_DESC_WAIT: if (desc_last) state_nx = ST_DATA_REQ;
            ST_DATA_REQ: begin
                if (frame_done)           state_nx = ctrl.run ? ST_DESC_REQ : ST_IDLE;
                else if (room && mem_ack) state_nx = ST_DATA_WAIT;
            end
            ST_DATA_WAIT: if (mem_rvalid && bcnt == BLEN_W'(1)) state_nx = ST_DATA_REQ;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wcnt    <= '0;
            bcnt    <= '0;
            src_ptr <= '0;
            remain  <= '0;
            link    <= '0;
            cur_src <= '0;
            cur_tag <= '0;
            cur_cmd <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_DESC_REQ: wcnt <= '0;
                ST_DESC_WAIT: if (mem_rvalid) begin
                    wcnt <= wcnt + 1'b1;
                    unique case (wcnt)
                        2'd0: link    <= mem_rdata;
                        2'd1: cur_src <= mem_rdata;
                        2'd2: cur_tag <= mem_rdata;
                        default: begin
                            cur_cmd <= mem_rdata;
                            remain  <= mem_rdata[LEN_W-1:0];
                            src_ptr <= cur_src;
                        end
                    endcase
                end
                ST_DATA_REQ: if (!frame_done && room && mem_ack) bcnt <= blen;
                ST_DATA_WAIT: if (mem_rvalid) begin
                    src_ptr <= src_ptr + 32'd4;
                    remain  <= remain - 1'b1;
                    bcnt    <= bcnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = '0;
        mem_len   = '0;
        push      = 1'b0;
        ev_end    = 1'b0;
        unique case (state)
            ST_DESC_REQ: begin
                mem_req  = 1'b1;
                mem_addr = dptr;
                mem_len  = BLEN_W'(DESC_WORDS);
            end
            ST_DATA_REQ: begin
                mem_req  = !frame_done && room;
                mem_addr = src_ptr;
                mem_len  = blen;
                ev_end   = frame_done && cur_cmd[30];
            end
            ST_DATA_WAIT: push = mem_rvalid;
            default: ;
        endcase
    end

    assign push_data = mem_rdata;
    assign dptr_load = desc_last;
    assign dptr_next = link;
    assign ev_start  = desc_last && mem_rdata[31];

endmodule

// File: rtl/fdma_fetch.sv
module fdma_fetch
    import fdf_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int FIFO_DEPTH = 32,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    output logic [4:0]  mem_len,
    input  logic        mem_ack,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic        pix_rd,
    output logic [31:0] pix_data,
    output logic        pix_empty,
    output logic        irq
);

    fdf_ctrl_t        ctrl;
    fdf_state_e       state;
    logic [31:0]      dptr;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_push;
    logic [31:0]      fifo_din;
    logic             dptr_load;
    logic [31:0]      dptr_next;
    logic [31:0]      cur_src;
    logic [31:0]      cur_tag;
    logic [31:0]      cur_cmd;
    logic             ev_start;
    logic             ev_end;
    logic             ev_ufl;
    logic             ufl_en;

    assign ev_ufl = pix_rd && pix_empty;
    assign ufl_en = ctrl.ufl_en;

    fdf_regs #(.LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dptr_load (dptr_load),
        .dptr_next (dptr_next),
        .cur_src   (cur_src),
        .cur_tag   (cur_tag),
        .cur_cmd   (cur_cmd),
        .ev_start  (ev_start),
        .ev_end    (ev_end),
        .ev_ufl    (ev_ufl),
        .ctrl      (ctrl),
        .dptr      (dptr),
        .irq       (irq)
    );

    fdf_seq #(.LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .dptr       (dptr),
        .fifo_cnt   (fifo_cnt),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_len    (mem_len),
        .mem_ack    (mem_ack),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .push       (fifo_push),
        .push_data  (fifo_din),
        .dptr_load  (dptr_load),
        .dptr_next  (dptr_next),
        .cur_src    (cur_src),
        .cur_tag    (cur_tag),
        .cur_cmd    (cur_cmd),
        .ev_start   (ev_start),
        .ev_end     (ev_end),
        .state      (state)
    );

    fdf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (pix_rd),
        .dout  (pix_data),
        .empty (pix_empty),
        .count (fifo_cnt)
    );

endmodule

// File: rtl/fdma_fetch_chk.sv
module fdma_fetch_chk #(
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [31:0]      mem_addr,
    input logic [4:0]       mem_len,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             fifo_push,
    input logic             pix_rd,
    input logic             pix_empty,
    input logic             ufl_en,
    input logic             irq
);

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len));

    a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != 5'd0) && (mem_len <= 5'd16));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fifo_cnt) == FIFO_DEPTH) |-> !fifo_push);

    a_r9_underrun_irq: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rd && pix_empty && ufl_en |=> irq);

    a_r12_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rd && !pix_empty && !fifo_push |=> fifo_cnt == $past(fifo_cnt) - 1'b1);

endmodule

bind fdma_fetch fdma_fetch_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_len   (mem_len),
    .fifo_cnt  (fifo_cnt),
    .fifo_push (fifo_push),
    .pix_rd    (pix_rd),
    .pix_empty (pix_empty),
    .ufl_en    (ufl_en),
    .irq       (irq)
);

// File: tb/fdma_fetch_bench.sv
`timescale 1ns/1ps
module fdma_fetch_bench;

    localparam int DEPTH = 16;
    localparam logic [31:0] D0 = 32'h320;
    localparam logic [31:0] D1 = 32'h330;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_ack = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        pix_rd = 1'b0;
    logic [31:0] pix_data;
    logic        pix_empty;
    logic        irq;

    fdma_fetch #(.LEN_W(24), .FIFO_DEPTH(DEPTH)) u_fdma_fetch (.*);

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] mem [256];

    // scenario state
    int L0, L1, bsz;
    int m_rem, m_src, m_flen, desc_seen;
    bit mbusy = 0;
    bit pop_en = 0, force_pop = 0;
    int c_frame, c_pos, pops;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0; mem_rvalid = 1'b0;
            if (rst_n && mem_req) begin
                logic [31:0] a;
                int n;
                a = mem_addr; n = int'(mem_len);
                mem_ack = 1'b1; mbusy = 1;
                if (a >= D0) begin
                    chk("R6 descriptor only after frame end", 32'(m_rem), 32'd0);
                    chk("R2 descriptor length", 32'(n), 32'd4);
                    chk("R6 descriptor address", a, (desc_seen == 0) ? D0 : D1);
                    m_flen = (desc_seen == 0) ? L0 : L1;
                    m_src  = (desc_seen == 0) ? 0 : 32'h100;
                    m_rem  = m_flen;
                    desc_seen++;
                end else begin
                    int e;
                    e = (m_rem < bsz) ? m_rem : bsz;
                    chk("R4 burst length", 32'(n), 32'(e));
                    chk("R4 burst address", a, 32'(m_src + 4 * (m_flen - m_rem)));
                    m_rem -= n;
                end
                for (int k = 0; k < n; k++) begin
                    @(negedge clk);
                    mem_ack = 1'b0;
                    if (k == 2) begin
                        mem_rvalid = 1'b0;
                        @(negedge clk);
                    end
                    mem_rvalid = 1'b1;
                    mem_rdata = mem[(a >> 2) + k];
                end
                mbusy = 0;
            end
        end
    end

    // consumer
    initial begin
        forever begin
            @(negedge clk);
            pix_rd = 1'b0;
            if (force_pop) begin
                pix_rd = 1'b1;
            end else if (rst_n && pop_en && !pix_empty) begin
                int len, base;
                pix_rd = 1'b1;
                len  = (c_frame == 0) ? L0 : L1;
                base = (c_frame == 0) ? 0 : 64;
                chk("R12 frame word order", pix_data, mem[base + c_pos]);
                pops++;
                c_pos++;
                if (c_pos == len) begin
                    c_pos = 0;
                    c_frame = 1;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        int lens [3][2];
        lens[0][0] = 1;  lens[0][1] = 5;
        lens[1][0] = 13; lens[1][1] = 20;
        lens[2][0] = 8;  lens[2][1] = 3;

        for (int i = 0; i < 200; i++) mem[i] = 32'h5A00_0000 + 32'(i) * 32'h0001_0003;
        for (int i = 200; i < 256; i++) mem[i] = '0;

        for (int cs = 0; cs < 9; cs++) begin
            int bc;
            logic [31:0] ctl;
            bc = cs / 3;
            L0 = lens[cs % 3][0]; L1 = lens[cs % 3][1];
            bsz = 4 << bc;
            mem[200] = D1; mem[201] = 32'h000; mem[202] = 32'hF00D_0000 + 32'(cs);
            mem[203] = 32'h8000_0000 | 32'(L0);
            mem[204] = D1; mem[205] = 32'h100; mem[206] = 32'hBEEF_0000 + 32'(cs);
            mem[207] = 32'h4000_0000 | 32'(L1);
            m_rem = 0; desc_seen = 0; c_frame = 0; c_pos = 0; pops = 0; pop_en = 0;

            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            if (cs == 0) begin
                @(negedge clk);
                chk("R1 fifo empty", 32'(pix_empty), 32'd1);
                chk("R1 irq low", 32'(irq), 32'd0);
                chk("R1 no request", 32'(mem_req), 32'd0);
                rreg(8'h30, v); chk("R1 ctrl zero", v, 0);
                rreg(8'h34, v); chk("R1 status zero", v, 0);
                rreg(8'h40, v); chk("R1 pointer zero", v, 0);
            end

            ctl = (32'(bc) << 28) | 32'h8 | ((cs % 2 == 0) ? 32'h1000 : 32'h2000);
            wreg(8'h40, D0);
            wreg(8'h30, ctl);
            pop_en = 1;
            while (pops < 2) @(negedge clk);
            pop_en = 0;
            repeat (200) @(negedge clk);
            chk("R5 stalled with full fifo, no request", 32'(mem_req), 32'd0);
            chk("R5 fifo holds data during stall", 32'(pix_empty), 32'd0);
            pop_en = 1;
            while (pops < L0 + 2 * L1) @(negedge clk);
            wreg(8'h30, ctl & ~32'h8);
            begin
                int quiet;
                quiet = 0;
                while (quiet < 60) begin
                    @(negedge clk);
                    if (!mem_req && !mbusy && pix_empty) quiet++;
                    else quiet = 0;
                end
            end
            chk("R11 stops on frame boundary", 32'(c_pos), 32'd0);
            chk("R6 self-link repeats frame", 32'(desc_seen >= 3), 32'd1);
            rreg(8'h40, v); chk("R6 pointer holds link", v, D1);
            rreg(8'h44, v); chk("R7 source readback", v, 32'h100);
            rreg(8'h48, v); chk("R7 tag readback", v, 32'hBEEF_0000 + 32'(cs));
            rreg(8'h4C, v); chk("R7 command readback", v, 32'h4000_0000 | 32'(L1));
            rreg(8'h34, v);
            chk("R8 gated event flags", v, (cs % 2 == 0) ? 32'h2 : 32'h4);
            chk("R10 irq follows flags", 32'(irq), 32'd1);
            wreg(8'h34, 32'h0);
            rreg(8'h34, v); chk("R10 write zero clears", v, 0);
            chk("R10 irq low after clear", 32'(irq), 32'd0);
        end

        // underrun
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wreg(8'h30, 32'h0);
        @(negedge clk); force_pop = 1; @(negedge clk); force_pop = 0;
        rreg(8'h34, v); chk("R9 underrun ignored when disabled", v, 0);
        wreg(8'h30, 32'h800);
        @(negedge clk); force_pop = 1; @(negedge clk); force_pop = 0;
        rreg(8'h34, v); chk("R9 underrun flag", v, 32'h1);
        chk("R9 irq on underrun", 32'(irq), 32'd1);
        wreg(8'h34, 32'h6);
        rreg(8'h34, v); chk("R10 AND clears bit 0", v, 0);

        finish_up();
    end

endmodule